// File: doc/BRIEF.md
# Stateless Memory Bus Arbiter

This block merges several master ports of a split command/response memory bus onto a single slave port. Every master presents a command stream (valid, ready, source tag, opcode, address, length, write data, byte mask, context) and receives a response stream (valid, ready, source tag, status opcode, read data, context). A command beat carries the address and the write data together. Each stream moves a beat only in a cycle where both valid and ready are high.

The arbiter keeps no per-transaction table. When it forwards a command, it extends the source tag with the index of the granted master, placed in the high bits. A response is steered back by decoding those index bits, and the bits are removed before the response reaches the master. No RAM or FIFO is needed, so the number of pending transactions has no limit. A round-robin pointer picks among requesting masters. The grant stays fixed for all beats of a write burst and moves on only when a command completes a burst: a read command, or the last beat of a write.

Top module: `mbus_arbiter`

## Requirements
- R1: The slave command source equals the granted master's index (high IDX_W bits) concatenated with that master's own source tag (low SRC_W bits). Opcode (0 read, 1 write), address, length, data, mask and context are copied unchanged from the granted master.
- R2: Only the granted master can see command ready, and it sees ready only while it is valid and the slave is ready. At most one command ready bit is high at any time.
- R3: After a burst from master k completes, the search for the next grant starts at master k+1, wrapping from N-1 to 0.
- R4: A read command completes its burst in one accepted beat, and a different master may be granted in the next cycle.
- R5: A write with length field L (byte count minus one) lasts L/(DATA_W/8)+1 accepted beats. The grant stays on the writing master for all of those beats, even while other masters request, the slave stalls, or the writer drops valid between beats. A write with L below DATA_W/8 is a single beat and releases the grant at once.
- R6: A response whose high IDX_W source bits equal i raises only the response valid of master i.
- R7: Response opcode (0 success, 1 error), data, context and the low SRC_W source bits are passed unchanged to the masters. The routing bits are removed.
- R8: Slave response ready equals the response ready of the master addressed by the index bits.
- R9: A response whose index is N or above is accepted (ready high) and dropped. No master sees it as valid.
- R10: After reset no burst is open and the round-robin search starts at master 0.
- R11: With no master requesting, the slave command valid stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| m_cmd_valid | input | N | Command valid per master |
| m_cmd_ready | output | N | Command ready per master |
| m_cmd_opcode | input | N | Command opcode per master, 1 = write |
| m_cmd_addr | input | N*ADDR_W | Byte address per master |
| m_cmd_len | input | N*LEN_W | Byte count minus one per master |
| m_cmd_data | input | N*DATA_W | Write data per master |
| m_cmd_mask | input | N*DATA_W/8 | Byte enables per master |
| m_cmd_source | input | N*SRC_W | Source tag per master |
| m_cmd_ctx | input | N*CTX_W | Context per master |
| s_cmd_valid | output | 1 | Command valid to slave |
| s_cmd_ready | input | 1 | Command ready from slave |
| s_cmd_opcode | output | 1 | Command opcode to slave |
| s_cmd_addr | output | ADDR_W | Address to slave |
| s_cmd_len | output | LEN_W | Length to slave |
| s_cmd_data | output | DATA_W | Write data to slave |
| s_cmd_mask | output | DATA_W/8 | Byte enables to slave |
| s_cmd_source | output | SRC_W+IDX_W | Extended source tag |
| s_cmd_ctx | output | CTX_W | Context to slave |
| s_rsp_valid | input | 1 | Response valid from slave |
| s_rsp_ready | output | 1 | Response ready to slave |
| s_rsp_opcode | input | 1 | Response status, 1 = error |
| s_rsp_data | input | DATA_W | Read data |
| s_rsp_source | input | SRC_W+IDX_W | Extended source tag |
| s_rsp_ctx | input | CTX_W | Context |
| m_rsp_valid | output | N | Response valid per master |
| m_rsp_ready | input | N | Response ready per master |
| m_rsp_opcode | output | 1 | Status, shared by all masters |
| m_rsp_data | output | DATA_W | Read data, shared by all masters |
| m_rsp_source | output | SRC_W | Stripped source tag, shared |
| m_rsp_ctx | output | CTX_W | Context, shared |

## Verification
The response path is tried with a table of index and ready combinations. The table covers addressed masters that are ready and not ready, non-addressed masters that are ready, and an out-of-range index, which separates correct steering from broadcasting or from ready taken from the wrong master. The command path is tried first with all masters issuing reads at once, which shows the rotation order and the wrap to master 0. It is then tried with a three-beat write while the other masters compete, and with a slave stall and an owner gap during the burst, to show that the grant holds until the counted last beat and not just until the owner pauses. A single-beat write shows that a short write releases the grant at once.

// File: rtl/mbus_arb_pkg.sv
package mbus_arb_pkg;

  // Width of a master index field; never zero so ports stay legal for N=1.
  function automatic int unsigned idx_width(int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // Zero-based index of the final beat of a burst of (len+1) bytes.
  function automatic int unsigned last_beat(int unsigned len, int unsigned bytes_per_beat);
    return len / bytes_per_beat;
  endfunction

  // Round-robin successor of a master index.
  function automatic int unsigned next_index(int unsigned cur, int unsigned n);
    return (cur + 1 >= n) ? 0 : cur + 1;
  endfunction

endpackage

// File: rtl/rr_pick.sv
module rr_pick #(
  parameter int N     = 3,
  parameter int IDX_W = 2
) (
  input  logic [N-1:0]     req,
  input  logic [IDX_W-1:0] start,
  output logic [IDX_W-1:0] pick,
  output logic             any
);
  // Scan from farthest to nearest so the requester closest to start wins.
  always_comb begin
    pick = '0;
    any  = 1'b0;
    for (int k = N - 1; k >= 0; k--) begin
      if (req[(int'(start) + k) % N]) begin
        pick = IDX_W'((int'(start) + k) % N);
        any  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/cmd_path.sv
module cmd_path
  import mbus_arb_pkg::*;
#(
  parameter int N      = 3,
  parameter int IDX_W  = 2,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 4,
  parameter int SRC_W  = 2,
  parameter int CTX_W  = 4,
  localparam int MASK_W = DATA_W / 8,
  localparam int OSRC_W = SRC_W + IDX_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [N-1:0]          m_valid,
  output logic [N-1:0]          m_ready,
  input  logic [N-1:0]          m_opcode,
  input  logic [N*ADDR_W-1:0]   m_addr,
  input  logic [N*LEN_W-1:0]    m_len,
  input  logic [N*DATA_W-1:0]   m_data,
  input  logic [N*MASK_W-1:0]   m_mask,
  input  logic [N*SRC_W-1:0]    m_source,
  input  logic [N*CTX_W-1:0]    m_ctx,
  output logic                  s_valid,
  input  logic                  s_ready,
  output logic                  s_opcode,
  output logic [ADDR_W-1:0]     s_addr,
  output logic [LEN_W-1:0]      s_len,
  output logic [DATA_W-1:0]     s_data,
  output logic [MASK_W-1:0]     s_mask,
  output logic [OSRC_W-1:0]     s_source,
  output logic [CTX_W-1:0]      s_ctx
);
  localparam int BYTES = DATA_W / 8;

  logic             busy_q;   // write burst open
  logic [IDX_W-1:0] owner_q;  // master holding the burst
  logic [IDX_W-1:0] ptr_q;    // round-robin search start
  logic [LEN_W-1:0] beat_q;   // beats already accepted in open burst

  logic [IDX_W-1:0] pick;
  logic             any;
  logic [IDX_W-1:0] sel;
  logic [SRC_W-1:0] sel_src;
  logic             fire;       // command beat accepted
  logic             end_burst;  // accepted beat closes the burst
  logic [LEN_W-1:0] last_idx;

  rr_pick #(.N(N), .IDX_W(IDX_W)) pick_i (
    .req(m_valid), .start(ptr_q), .pick(pick), .any(any)
  );

  assign sel = busy_q ? owner_q : pick;

  always_comb begin
    s_valid  = 1'b0;
    s_opcode = 1'b0;
    s_addr   = '0;
    s_len    = '0;
    s_data   = '0;
    s_mask   = '0;
    sel_src  = '0;
    s_ctx    = '0;
    for (int i = 0; i < N; i++) begin
      if (sel == IDX_W'(i)) begin
        s_valid  = m_valid[i];
        s_opcode = m_opcode[i];
        s_addr   = m_addr[i*ADDR_W +: ADDR_W];
        s_len    = m_len[i*LEN_W +: LEN_W];
        s_data   = m_data[i*DATA_W +: DATA_W];
        s_mask   = m_mask[i*MASK_W +: MASK_W];
        sel_src  = m_source[i*SRC_W +: SRC_W];
        s_ctx    = m_ctx[i*CTX_W +: CTX_W];
      end
    end
  end

  assign s_source = {sel, sel_src};

  always_comb begin
    for (int i = 0; i < N; i++) m_ready[i] = s_ready && s_valid && (sel == IDX_W'(i));
  end

  assign fire      = s_valid && s_ready;
  assign last_idx  = LEN_W'(last_beat(int'(s_len), BYTES));
  assign end_burst = !s_opcode || (beat_q == last_idx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      owner_q <= '0;
      ptr_q   <= '0;
      beat_q  <= '0;
    end else if (fire) begin
      if (end_burst) begin
        busy_q <= 1'b0;
        beat_q <= '0;
        ptr_q  <= IDX_W'(next_index(int'(sel), N));
      end else begin
        busy_q  <= 1'b1;
        owner_q <= sel;
        beat_q  <= beat_q + 1'b1;
      end
    end
  end

  assert_one_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(m_ready));
  assert_ready_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    s_valid |-> ((|m_ready) == s_ready));
  assert_hold_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !end_burst) |=> (sel == $past(sel)));
  assert_tag_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    s_valid |-> (int'(s_source[OSRC_W-1 -: IDX_W]) < N));
endmodule

// File: rtl/rsp_router.sv
module rsp_router #(
  parameter int N      = 3,
  parameter int IDX_W  = 2,
  parameter int DATA_W = 32,
  parameter int SRC_W  = 2,
  parameter int CTX_W  = 4,
  localparam int OSRC_W = SRC_W + IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic              s_opcode,
  input  logic [DATA_W-1:0] s_data,
  input  logic [OSRC_W-1:0] s_source,
  input  logic [CTX_W-1:0]  s_ctx,
  output logic [N-1:0]      m_valid,
  input  logic [N-1:0]      m_ready,
  output logic              m_opcode,
  output logic [DATA_W-1:0] m_data,
  output logic [SRC_W-1:0]  m_source,
  output logic [CTX_W-1:0]  m_ctx
);
  logic [IDX_W-1:0] dest;
  logic             in_range;  // index names an existing master
  logic             dest_ready;

  assign dest     = s_source[OSRC_W-1 -: IDX_W];
  assign in_range = int'(dest) < N;

  always_comb begin
    dest_ready = 1'b0;
    for (int i = 0; i < N; i++) begin
      m_valid[i] = s_valid && (dest == IDX_W'(i));
      if (dest == IDX_W'(i)) dest_ready = m_ready[i];
    end
  end

  assign s_ready  = in_range ? dest_ready : 1'b1;
  assign m_opcode = s_opcode;
  assign m_data   = s_data;
  assign m_source = s_source[SRC_W-1:0];
  assign m_ctx    = s_ctx;

  assert_one_rsp_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(m_valid));
  assert_drop_stray_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && !in_range) |-> (m_valid == '0 && s_ready));
  assert_ready_matches_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|m_valid) |-> (s_ready == |(m_valid & m_ready)));
endmodule

// File: rtl/mbus_arbiter.sv
module mbus_arbiter
  import mbus_arb_pkg::*;
#(
  parameter int N      = 3,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 4,
  parameter int SRC_W  = 2,
  parameter int CTX_W  = 4,
  localparam int IDX_W  = idx_width(N),
  localparam int MASK_W = DATA_W / 8,
  localparam int OSRC_W = SRC_W + IDX_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N-1:0]        m_cmd_valid,
  output logic [N-1:0]        m_cmd_ready,
  input  logic [N-1:0]        m_cmd_opcode,
  input  logic [N*ADDR_W-1:0] m_cmd_addr,
  input  logic [N*LEN_W-1:0]  m_cmd_len,
  input  logic [N*DATA_W-1:0] m_cmd_data,
  input  logic [N*MASK_W-1:0] m_cmd_mask,
  input  logic [N*SRC_W-1:0]  m_cmd_source,
  input  logic [N*CTX_W-1:0]  m_cmd_ctx,
  output logic                s_cmd_valid,
  input  logic                s_cmd_ready,
  output logic                s_cmd_opcode,
  output logic [ADDR_W-1:0]   s_cmd_addr,
  output logic [LEN_W-1:0]    s_cmd_len,
  output logic [DATA_W-1:0]   s_cmd_data,
  output logic [MASK_W-1:0]   s_cmd_mask,
  output logic [OSRC_W-1:0]   s_cmd_source,
  output logic [CTX_W-1:0]    s_cmd_ctx,
  input  logic                s_rsp_valid,
  output logic                s_rsp_ready,
  input  logic                s_rsp_opcode,
  input  logic [DATA_W-1:0]   s_rsp_data,
  input  logic [OSRC_W-1:0]   s_rsp_source,
  input  logic [CTX_W-1:0]    s_rsp_ctx,
  output logic [N-1:0]        m_rsp_valid,
  input  logic [N-1:0]        m_rsp_ready,
  output logic                m_rsp_opcode,
  output logic [DATA_W-1:0]   m_rsp_data,
  output logic [SRC_W-1:0]    m_rsp_source,
  output logic [CTX_W-1:0]    m_rsp_ctx
);
  cmd_path #(
    .N(N), .IDX_W(IDX_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .LEN_W(LEN_W), .SRC_W(SRC_W), .CTX_W(CTX_W)
  ) cmd_i (
    .clk(clk), .rst_n(rst_n),
    .m_valid(m_cmd_valid), .m_ready(m_cmd_ready), .m_opcode(m_cmd_opcode),
    .m_addr(m_cmd_addr), .m_len(m_cmd_len), .m_data(m_cmd_data),
    .m_mask(m_cmd_mask), .m_source(m_cmd_source), .m_ctx(m_cmd_ctx),
    .s_valid(s_cmd_valid), .s_ready(s_cmd_ready), .s_opcode(s_cmd_opcode),
    .s_addr(s_cmd_addr), .s_len(s_cmd_len), .s_data(s_cmd_data),
    .s_mask(s_cmd_mask), .s_source(s_cmd_source), .s_ctx(s_cmd_ctx)
  );

  rsp_router #(
    .N(N), .IDX_W(IDX_W), .DATA_W(DATA_W), .SRC_W(SRC_W), .CTX_W(CTX_W)
  ) rsp_i (
    .clk(clk), .rst_n(rst_n),
    .s_valid(s_rsp_valid), .s_ready(s_rsp_ready), .s_opcode(s_rsp_opcode),
    .s_data(s_rsp_data), .s_source(s_rsp_source), .s_ctx(s_rsp_ctx),
    .m_valid(m_rsp_valid), .m_ready(m_rsp_ready), .m_opcode(m_rsp_opcode),
    .m_data(m_rsp_data), .m_source(m_rsp_source), .m_ctx(m_rsp_ctx)
  );
endmodule

// File: tb/mbus_arbiter_tb.sv
`timescale 1ns/100ps
module mbus_arbiter_tb_top;
  localparam int N = 3, AW = 16, DW = 32, LW = 4, SW = 2, CW = 4, IW = 2, MW = DW/8, OW = SW + IW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [N-1:0] m_cmd_valid, m_cmd_ready, m_cmd_opcode;
  logic [N*AW-1:0] m_cmd_addr;
  logic [N*LW-1:0] m_cmd_len;
  logic [N*DW-1:0] m_cmd_data;
  logic [N*MW-1:0] m_cmd_mask;
  logic [N*SW-1:0] m_cmd_source;
  logic [N*CW-1:0] m_cmd_ctx;
  logic s_cmd_valid, s_cmd_ready, s_cmd_opcode;
  logic [AW-1:0] s_cmd_addr;
  logic [LW-1:0] s_cmd_len;
  logic [DW-1:0] s_cmd_data;
  logic [MW-1:0] s_cmd_mask;
  logic [OW-1:0] s_cmd_source;
  logic [CW-1:0] s_cmd_ctx;
  logic s_rsp_valid, s_rsp_ready, s_rsp_opcode;
  logic [DW-1:0] s_rsp_data;
  logic [OW-1:0] s_rsp_source;
  logic [CW-1:0] s_rsp_ctx;
  logic [N-1:0] m_rsp_valid, m_rsp_ready;
  logic m_rsp_opcode;
  logic [DW-1:0] m_rsp_data;
  logic [SW-1:0] m_rsp_source;
  logic [CW-1:0] m_rsp_ctx;

  mbus_arbiter dut_i (.*);

  int total = 0, bad = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic set_cmd(input int i, input bit v, input bit op, input logic [AW-1:0] a,
                         input logic [LW-1:0] l, input logic [DW-1:0] d, input logic [SW-1:0] s,
                         input logic [CW-1:0] c);
    m_cmd_valid[i] = v;
    m_cmd_opcode[i] = op;
    m_cmd_addr[i*AW +: AW] = a;
    m_cmd_len[i*LW +: LW] = l;
    m_cmd_data[i*DW +: DW] = d;
    m_cmd_mask[i*MW +: MW] = MW'(4'hF - i);
    m_cmd_source[i*SW +: SW] = s;
    m_cmd_ctx[i*CW +: CW] = c;
  endtask

  // {index[1:0], master ready[2:0], expected valid[2:0], expected slave ready}
  localparam logic [8:0] RSP_VEC [6] = '{
    {2'd0, 3'b001, 3'b001, 1'b1},
    {2'd0, 3'b110, 3'b001, 1'b0},
    {2'd1, 3'b010, 3'b010, 1'b1},
    {2'd2, 3'b011, 3'b100, 1'b0},
    {2'd2, 3'b100, 3'b100, 1'b1},
    {2'd3, 3'b000, 3'b000, 1'b1}
  };

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    m_cmd_valid = '0; m_cmd_opcode = '0; m_cmd_addr = '0; m_cmd_len = '0;
    m_cmd_data = '0; m_cmd_mask = '0; m_cmd_source = '0; m_cmd_ctx = '0;
    s_cmd_ready = 1'b0; s_rsp_valid = 1'b0; s_rsp_opcode = 1'b0;
    s_rsp_data = '0; s_rsp_source = '0; s_rsp_ctx = '0; m_rsp_ready = '0;
    tick(); tick();
    rst_n = 1'b1;
    #1;
    chk(s_cmd_valid == 1'b0, "R11 idle valid", 64'(s_cmd_valid), 0);

    // Response routing table (R6 R8 R9 R7)
    for (int v = 0; v < 6; v++) begin
      s_rsp_valid = 1'b1;
      s_rsp_source = {RSP_VEC[v][8:7], 2'(v)};
      s_rsp_data = 32'hD000_0000 + 32'(v);
      s_rsp_ctx = 4'(v + 7);
      s_rsp_opcode = v[0];
      m_rsp_ready = RSP_VEC[v][6:4];
      #1;
      chk(m_rsp_valid == RSP_VEC[v][3:1], "R6 rsp steering", 64'(m_rsp_valid), 64'(RSP_VEC[v][3:1]));
      chk(s_rsp_ready == RSP_VEC[v][0], (RSP_VEC[v][8:7] == 2'd3) ? "R9 stray accept" : "R8 rsp ready",
          64'(s_rsp_ready), 64'(RSP_VEC[v][0]));
      chk(m_rsp_source == 2'(v) && m_rsp_data == 32'hD000_0000 + 32'(v) && m_rsp_ctx == 4'(v + 7)
          && m_rsp_opcode == v[0], "R7 rsp payload", 64'({m_rsp_source, m_rsp_ctx}), 64'({2'(v), 4'(v + 7)}));
      tick();
    end
    s_rsp_valid = 1'b0; m_rsp_ready = 3'b111; #1;
    chk(m_rsp_valid == 3'b000, "R6 no rsp valid", 64'(m_rsp_valid), 0);

    // All masters read at once: rotation 0,1,2,0 (R10 R3 R4 R1)
    set_cmd(0, 1, 0, 16'h1000, 4'd3, 32'hA0, 2'd1, 4'd1);
    set_cmd(1, 1, 0, 16'h2000, 4'd3, 32'hA1, 2'd2, 4'd2);
    set_cmd(2, 1, 0, 16'h3000, 4'd3, 32'hA2, 2'd3, 4'd3);
    s_cmd_ready = 1'b1;
    for (int k = 0; k < 4; k++) begin
      #1;
      chk(s_cmd_source == {2'(k % 3), 2'((k % 3) + 1)}, "R3 R10 rotation tag", 64'(s_cmd_source),
          64'({2'(k % 3), 2'((k % 3) + 1)}));
      chk(m_cmd_ready == 3'(1 << (k % 3)), "R4 R2 read grant", 64'(m_cmd_ready), 64'(1 << (k % 3)));
      chk(s_cmd_addr == 16'(16'h1000 * ((k % 3) + 1)), "R1 addr copy", 64'(s_cmd_addr),
          64'(16'h1000 * ((k % 3) + 1)));
      tick();
    end
    m_cmd_valid = '0;

    // Three-beat write on master 2 (R5 R1); pointer now at 1
    set_cmd(2, 1, 1, 16'h3300, 4'd11, 32'hBEEF_0001, 2'd0, 4'd5);
    #1;
    chk(s_cmd_source == 4'h8 && s_cmd_opcode && s_cmd_len == 4'd11 && s_cmd_ctx == 4'd5
        && s_cmd_data == 32'hBEEF_0001 && s_cmd_mask == 4'hD, "R1 write fields",
        64'({s_cmd_source, s_cmd_len, s_cmd_ctx}), 64'({4'h8, 4'd11, 4'd5}));
    tick();
    set_cmd(0, 1, 0, 16'h1100, 4'd0, 32'h0, 2'd1, 4'd1);
    set_cmd(1, 1, 0, 16'h2100, 4'd0, 32'h0, 2'd2, 4'd2);
    s_cmd_ready = 1'b0; #1;
    chk(s_cmd_valid && s_cmd_source[3:2] == 2'd2 && m_cmd_ready == 3'b000, "R5 hold under stall",
        64'({s_cmd_source, m_cmd_ready}), 64'({4'h8, 3'b000}));
    tick();
    s_cmd_ready = 1'b1; m_cmd_valid[2] = 1'b0; #1;
    chk(s_cmd_valid == 1'b0 && m_cmd_ready == 3'b000, "R5 hold over owner gap",
        64'({s_cmd_valid, m_cmd_ready}), 0);
    tick();
    m_cmd_valid[2] = 1'b1; m_cmd_data[2*DW +: DW] = 32'hBEEF_0002; #1;
    chk(m_cmd_ready == 3'b100 && s_cmd_data == 32'hBEEF_0002, "R5 second beat",
        64'(m_cmd_ready), 64'(3'b100));
    tick();
    #1;
    chk(m_cmd_ready == 3'b100 && s_cmd_source[3:2] == 2'd2, "R5 last beat still owned",
        64'(m_cmd_ready), 64'(3'b100));
    tick();
    m_cmd_valid[2] = 1'b0; #1;
    chk(s_cmd_source[3:2] == 2'd0 && m_cmd_ready == 3'b001, "R3 wrap after burst",
        64'(m_cmd_ready), 64'(3'b001));
    tick();
    m_cmd_valid[0] = 1'b0; #1;
    chk(s_cmd_source[3:2] == 2'd1 && m_cmd_ready == 3'b010, "R3 next after 0",
        64'(m_cmd_ready), 64'(3'b010));
    tick();
    m_cmd_valid = '0;

    // Single-beat write releases grant at once (R5); pointer now at 2
    set_cmd(2, 1, 1, 16'h3400, 4'd3, 32'hCAFE, 2'd1, 4'd6);
    set_cmd(0, 1, 0, 16'h1200, 4'd0, 32'h0, 2'd3, 4'd1);
    #1;
    chk(m_cmd_ready == 3'b100, "R5 short write granted", 64'(m_cmd_ready), 64'(3'b100));
    tick();
    #1;
    chk(m_cmd_ready == 3'b001 && s_cmd_source == 4'h3, "R5 short write released",
        64'(s_cmd_source), 64'(4'h3));
    tick();
    m_cmd_valid = '0; #1;
    chk(s_cmd_valid == 1'b0, "R11 idle after traffic", 64'(s_cmd_valid), 0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule